// File: doc/BRIEF.md
# Iterative AES-128 Block-Chaining Encryption Engine

This block encrypts 128-bit data blocks with AES-128 under one of four block-chaining modes (ECB, CBC, CFB, OFB). A single round circuit is reused once per clock, so a block takes as many cycles as the programmed round count. The host first writes the round keys into a 16-entry internal key store. It then issues a configuration pulse that fixes the chaining mode, the round count and the initial chaining value. After that it presents blocks one at a time while the engine is idle.

The chaining value stays inside the engine from one block to the next. A start stage combines the incoming block, or the stored chaining value, with the whitening key before the first round. A finish stage applies the mode's feedback XOR and updates the chaining value. The round count can be set anywhere from 1 to 16, so the host can observe partial encryptions. With a count of 10 and the standard expanded key, the output is standard AES-128.

Top module: `aes_chain_engine`

## Requirements
- R1: While reset is active, and after it until the first accepted block, `busy` and `done` are 0 and `blk_out` is all zeros.
- R2: Key store entry 0 is XORed into the block before round 1. Round r uses entry (r mod 16), so round 16 uses entry 0 again. A key write takes effect at the clock edge where `key_we` is high.
- R3: A full round applies byte substitution, then row shift (row r rotated left by r), then column mix, then XOR with the round key. The last programmed round omits the column mix. Byte 0 is `[127:120]`, and column c holds bytes 4c..4c+3. With 10 rounds and the standard AES-128 expansion of key 2b7e151628aed2a6abf7158809cf4f3c, input 3243f6a8885a308d313198a2e0370734 gives 3925841d02dc09fbdc118597196a0b32.
- R4: `start_rounds_m1` holds the round count minus one (1..16 rounds). After a block is accepted, `busy` is high for exactly that many cycles. `done` is then high for one cycle with `busy` low, and `blk_out` changes only in that cycle and holds afterwards.
- R5: A `start` pulse while idle latches the mode (2'b00 ECB, 2'b01 CBC, 2'b10 CFB, 2'b11 OFB), the round count, and `start_iv` as the chaining value. A `start` while busy is ignored.
- R6: `blk_valid` is accepted only when idle and with `start` low. It is ignored while busy or when `start` is high in the same cycle.
- R7: ECB: the output is the encryption of the input block, and the chaining value is unchanged.
- R8: CBC: the input block XOR the chaining value is encrypted. The output becomes the new chaining value.
- R9: CFB: the chaining value is encrypted and XORed with the input block. That output becomes the new chaining value.
- R10: OFB: the chaining value is encrypted to a keystream, which becomes the new chaining value. The output is the keystream XOR the input block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_we | input | 1 | Key store write enable |
| key_addr | input | 4 | Key store entry to write |
| key_data | input | 128 | Round key to write |
| start | input | 1 | Configuration pulse |
| start_mode | input | 2 | Chaining mode to latch |
| start_rounds_m1 | input | 4 | Round count minus one |
| start_iv | input | 128 | Initial chaining value |
| blk_valid | input | 1 | Input block present |
| blk_in | input | 128 | Input data block |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle result pulse |
| blk_out | output | 128 | Result block, held until the next result |

## Verification
The bench builds the engine with its default parameters: 16 key entries and a round limit of 16. These values reach both the one-round minimum and the sixteen-round maximum, where round 16 wraps back to key entry 0. Entries 11 to 15 hold keys that differ from the standard expansion, so the wrap and the high-round keys both show up in the output. Three consecutive blocks in each chaining mode carry the internal chaining value across block boundaries. Configuration and block pulses issued while busy check that the in-flight run and the latched settings are left untouched.

// File: rtl/aes_eng_pkg.sv
package aes_eng_pkg;

  localparam int BLK_W  = 128;
  localparam int BYTES  = BLK_W / 8;

  typedef enum logic [1:0] {
    MODE_ECB = 2'b00,
    MODE_CBC = 2'b01,
    MODE_CFB = 2'b10,
    MODE_OFB = 2'b11
  } chain_mode_e;

  // multiply by x in GF(2^8) modulo x^8+x^4+x^3+x+1
  function automatic logic [7:0] gf_xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] aa;
    acc = 8'h00;
    aa  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ aa;
      aa = gf_xt(aa);
    end
    return acc;
  endfunction

  // inverse as a^254 by square-and-multiply (zero maps to zero)
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] res;
    logic [7:0] pw;
    logic [7:0] ex;
    res = 8'h01;
    pw  = a;
    ex  = 8'hfe;
    for (int i = 0; i < 8; i++) begin
      if (ex[i]) res = gf_mul(res, pw);
      pw = gf_mul(pw, pw);
    end
    return res;
  endfunction

  function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  function automatic logic [7:0] sub_byte(input logic [7:0] a);
    logic [7:0] q;
    q = gf_inv(a);
    return q ^ rotl8(q, 1) ^ rotl8(q, 2) ^ rotl8(q, 3) ^ rotl8(q, 4) ^ 8'h63;
  endfunction

endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
  import aes_eng_pkg::*;
(
  input  logic [7:0] byte_i,
  output logic [7:0] byte_o
);
  assign byte_o = sub_byte(byte_i);
endmodule

// File: rtl/aes_round.sv
module aes_round
  import aes_eng_pkg::*;
(
  input  logic [BLK_W-1:0] state_i,
  input  logic [BLK_W-1:0] rkey_i,
  input  logic             final_i,
  output logic [BLK_W-1:0] state_o
);
  logic [7:0] in_b  [BYTES];
  logic [7:0] sub_b [BYTES];
  logic [7:0] shf_b [BYTES];
  logic [7:0] mix_b [BYTES];

  genvar gb, gc, gr;
  generate
    for (gb = 0; gb < BYTES; gb++) begin : g_sub
      assign in_b[gb] = state_i[BLK_W-1-8*gb -: 8];
      aes_sbox u_sbox (.byte_i(in_b[gb]), .byte_o(sub_b[gb]));
    end

    for (gc = 0; gc < 4; gc++) begin : g_col
      for (gr = 0; gr < 4; gr++) begin : g_row
        localparam int SRC = 4 * ((gc + gr) % 4) + gr;
        assign shf_b[4*gc+gr] = sub_b[SRC];
      end
      logic [7:0] a0, a1, a2, a3;
      assign a0 = shf_b[4*gc];
      assign a1 = shf_b[4*gc+1];
      assign a2 = shf_b[4*gc+2];
      assign a3 = shf_b[4*gc+3];
      assign mix_b[4*gc]   = gf_xt(a0) ^ gf_xt(a1) ^ a1 ^ a2 ^ a3;
      assign mix_b[4*gc+1] = a0 ^ gf_xt(a1) ^ gf_xt(a2) ^ a2 ^ a3;
      assign mix_b[4*gc+2] = a0 ^ a1 ^ gf_xt(a2) ^ gf_xt(a3) ^ a3;
      assign mix_b[4*gc+3] = gf_xt(a0) ^ a0 ^ a1 ^ a2 ^ gf_xt(a3);
    end

    for (gb = 0; gb < BYTES; gb++) begin : g_key
      assign state_o[BLK_W-1-8*gb -: 8] =
        (final_i ? shf_b[gb] : mix_b[gb]) ^ rkey_i[BLK_W-1-8*gb -: 8];
    end
  endgenerate
endmodule

// File: rtl/aes_key_ram.sv
module aes_key_ram #(
  parameter int NUM_KEYS = 16,
  parameter int DATA_W   = 128,
  localparam int AW      = $clog2(NUM_KEYS)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr_a,
  output logic [DATA_W-1:0] rdata_a,
  input  logic [AW-1:0]     raddr_b,
  output logic [DATA_W-1:0] rdata_b
);
  logic [DATA_W-1:0] mem [NUM_KEYS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/aes_mode_xform.sv
module aes_mode_xform
  import aes_eng_pkg::*;
(
  input  chain_mode_e      mode_i,
  input  logic [BLK_W-1:0] new_blk_i,
  input  logic [BLK_W-1:0] held_blk_i,
  input  logic [BLK_W-1:0] chain_i,
  input  logic [BLK_W-1:0] core_i,
  output logic [BLK_W-1:0] init_o,
  output logic [BLK_W-1:0] fin_o,
  output logic [BLK_W-1:0] fin_chain_o
);
  always_comb begin
    unique case (mode_i)
      MODE_ECB: init_o = new_blk_i;
      MODE_CBC: init_o = new_blk_i ^ chain_i;
      default:  init_o = chain_i;
    endcase
  end

  always_comb begin
    unique case (mode_i)
      MODE_ECB: begin fin_o = core_i;              fin_chain_o = chain_i; end
      MODE_CBC: begin fin_o = core_i;              fin_chain_o = core_i;  end
      MODE_CFB: begin fin_o = core_i ^ held_blk_i; fin_chain_o = core_i ^ held_blk_i; end
      default:  begin fin_o = core_i ^ held_blk_i; fin_chain_o = core_i;  end
    endcase
  end
endmodule

// File: rtl/aes_chain_engine.sv
module aes_chain_engine
  import aes_eng_pkg::*;
#(
  parameter int NUM_KEYS   = 16,
  parameter int MAX_ROUNDS = 16,
  localparam int KA_W      = $clog2(NUM_KEYS),
  localparam int CNT_W     = $clog2(MAX_ROUNDS),
  localparam int RND_W     = CNT_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             key_we,
  input  logic [KA_W-1:0]  key_addr,
  input  logic [127:0]     key_data,
  input  logic             start,
  input  logic [1:0]       start_mode,
  input  logic [CNT_W-1:0] start_rounds_m1,
  input  logic [127:0]     start_iv,
  input  logic             blk_valid,
  input  logic [127:0]     blk_in,
  output logic             busy,
  output logic             done,
  output logic [127:0]     blk_out
);
  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  // state
  logic             busy_q,  busy_d;
  logic             done_q,  done_d;
  logic [RND_W-1:0] rnd_q,   rnd_d;
  logic [BLK_W-1:0] st_q,    st_d;
  logic [BLK_W-1:0] pt_q,    pt_d;
  logic [BLK_W-1:0] chain_q, chain_d;
  logic [BLK_W-1:0] res_q,   res_d;
  chain_mode_e      mode_q,  mode_d;
  logic [CNT_W-1:0] nrm1_q,  nrm1_d;

  // datapath nets
  logic [BLK_W-1:0] key_white, key_round, round_out;
  logic [BLK_W-1:0] init_blk, fin_blk, fin_chain;
  logic [RND_W-1:0] rnd_total;
  logic             last_rnd, take_cfg, take_blk;

  assign rnd_total = RND_W'(nrm1_q) + RND_W'(1);
  assign last_rnd  = (rnd_q == rnd_total);
  assign take_cfg  = !busy_q && start;
  assign take_blk  = !busy_q && !start && blk_valid;

  aes_key_ram #(.NUM_KEYS(NUM_KEYS), .DATA_W(BLK_W)) u_keys (
    .clk     (clk),
    .we      (key_we),
    .waddr   (key_addr),
    .wdata   (key_data),
    .raddr_a ('0),
    .rdata_a (key_white),
    .raddr_b (rnd_q[KA_W-1:0]),
    .rdata_b (key_round)
  );

  aes_round u_round (
    .state_i (st_q),
    .rkey_i  (key_round),
    .final_i (last_rnd),
    .state_o (round_out)
  );

  aes_mode_xform u_xform (
    .mode_i      (mode_q),
    .new_blk_i   (blk_in),
    .held_blk_i  (pt_q),
    .chain_i     (chain_q),
    .core_i      (round_out),
    .init_o      (init_blk),
    .fin_o       (fin_blk),
    .fin_chain_o (fin_chain)
  );

  // next state
  always_comb begin
    busy_d  = busy_q;
    done_d  = 1'b0;
    rnd_d   = rnd_q;
    st_d    = st_q;
    pt_d    = pt_q;
    chain_d = chain_q;
    res_d   = res_q;
    mode_d  = mode_q;
    nrm1_d  = nrm1_q;
    if (take_cfg) begin
      mode_d  = chain_mode_e'(start_mode);
      nrm1_d  = start_rounds_m1;
      chain_d = start_iv;
    end else if (take_blk) begin
      pt_d    = blk_in;
      st_d    = init_blk ^ key_white;
      rnd_d   = RND_W'(1);
      busy_d  = 1'b1;
    end else if (busy_q) begin
      st_d    = round_out;
      rnd_d   = rnd_q + RND_W'(1);
      if (last_rnd) begin
        busy_d  = 1'b0;
        done_d  = 1'b1;
        res_d   = fin_blk;
        chain_d = fin_chain;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rnd_q   <= '0;
      st_q    <= '0;
      pt_q    <= '0;
      chain_q <= '0;
      res_q   <= '0;
      mode_q  <= MODE_ECB;
      nrm1_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      rnd_q   <= rnd_d;
      st_q    <= st_d;
      pt_q    <= pt_d;
      chain_q <= chain_d;
      res_q   <= res_d;
      mode_q  <= mode_d;
      nrm1_q  <= nrm1_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign blk_out = res_q;
endmodule

// File: rtl/aes_chain_engine_chk.sv
module aes_chain_engine_chk #(
  parameter int MAX_ROUNDS = 16,
  localparam int CNT_W     = $clog2(MAX_ROUNDS),
  localparam int RUN_W     = CNT_W + 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             start,
  input logic             blk_valid,
  input logic [127:0]     blk_out,
  input logic [1:0]       mode_q,
  input logic [CNT_W-1:0] nrm1_q
);
  logic [RUN_W-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_cnt <= '0;
    else if (busy) run_cnt <= run_cnt + RUN_W'(1);
    else           run_cnt <= '0;
  end

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R4
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(blk_out)); // R4
  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_cnt < RUN_W'(MAX_ROUNDS))); // R4
  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_cnt == RUN_W'(nrm1_q) + RUN_W'(1))); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(mode_q) && $stable(nrm1_q))); // R5
  AST_BLOCK_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start && blk_valid) |=> busy); // R6
endmodule

bind aes_chain_engine aes_chain_engine_chk #(.MAX_ROUNDS(MAX_ROUNDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .busy      (busy),
  .done      (done),
  .start     (start),
  .blk_valid (blk_valid),
  .blk_out   (blk_out),
  .mode_q    (mode_q),
  .nrm1_q    (nrm1_q)
);

// File: tb/aes_chain_engine_test.sv
module aes_chain_engine_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         key_we;
  logic [3:0]   key_addr;
  logic [127:0] key_data;
  logic         start;
  logic [1:0]   start_mode;
  logic [3:0]   start_rounds_m1;
  logic [127:0] start_iv;
  logic         blk_valid;
  logic [127:0] blk_in;
  logic         busy, done;
  logic [127:0] blk_out;

  always #4 clk = ~clk; // 125 MHz

  aes_chain_engine uut (.*);

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string phase = "R1";

  // ---------------- reference arithmetic ----------------
  logic [7:0]   sb [256];
  logic [127:0] km [16];      // model's view of the key store
  logic [127:0] host_keys [16];

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] v, input int n);
    return (v << n) | (v >> (8 - n));
  endfunction

  task automatic build_sbox();
    logic [7:0] p, q;
    p = 8'h01; q = 8'h01;
    do begin
      p = p ^ {p[6:0], 1'b0} ^ (p[7] ? 8'h1b : 8'h00);
      q = q ^ {q[6:0], 1'b0};
      q = q ^ {q[5:0], 2'b00};
      q = q ^ {q[3:0], 4'h0};
      if (q[7]) q = q ^ 8'h09;
      sb[p] = q ^ rl(q, 1) ^ rl(q, 2) ^ rl(q, 3) ^ rl(q, 4) ^ 8'h63;
    end while (p != 8'h01);
    sb[0] = 8'h63;
  endtask

  task automatic expand_key(input logic [127:0] k);
    logic [31:0] w [44];
    logic [31:0] t;
    logic [7:0]  rc;
    rc = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127-32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      t = w[i-1];
      if (i % 4 == 0) begin
        t = {sb[t[23:16]], sb[t[15:8]], sb[t[7:0]], sb[t[31:24]]} ^ {rc, 24'h0};
        rc = xt(rc);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r < 11; r++) host_keys[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
    for (int r = 11; r < 16; r++) host_keys[r] = {16{8'(r * 29 + 5)}} ^ {4{32'h9e3779b9}};
  endtask

  function automatic logic [127:0] ref_enc(input logic [127:0] din, input int n);
    logic [7:0] s [16];
    logic [7:0] t [16];
    logic [127:0] o;
    for (int b = 0; b < 16; b++) s[b] = din[127-8*b -: 8] ^ km[0][127-8*b -: 8];
    for (int r = 1; r <= n; r++) begin
      for (int b = 0; b < 16; b++) t[b] = sb[s[b]];
      for (int c = 0; c < 4; c++)
        for (int rw = 0; rw < 4; rw++) s[4*c+rw] = t[4*((c+rw)%4)+rw];
      if (r != n) begin
        for (int c = 0; c < 4; c++) begin
          t[4*c]   = xt(s[4*c]) ^ xt(s[4*c+1]) ^ s[4*c+1] ^ s[4*c+2] ^ s[4*c+3];
          t[4*c+1] = s[4*c] ^ xt(s[4*c+1]) ^ xt(s[4*c+2]) ^ s[4*c+2] ^ s[4*c+3];
          t[4*c+2] = s[4*c] ^ s[4*c+1] ^ xt(s[4*c+2]) ^ xt(s[4*c+3]) ^ s[4*c+3];
          t[4*c+3] = xt(s[4*c]) ^ s[4*c] ^ s[4*c+1] ^ s[4*c+2] ^ xt(s[4*c+3]);
        end
      end else begin
        for (int b = 0; b < 16; b++) t[b] = s[b];
      end
      for (int b = 0; b < 16; b++) s[b] = t[b] ^ km[r % 16][127-8*b -: 8];
    end
    for (int b = 0; b < 16; b++) o[127-8*b -: 8] = s[b];
    return o;
  endfunction

  // ---------------- cycle model ----------------
  logic         m_busy = 1'b0, m_done = 1'b0;
  logic [127:0] m_res = '0, m_chain = '0, p_res = '0, p_chain = '0;
  logic [1:0]   m_mode = 2'b00;
  int           m_n = 1, m_left = 0;

  always @(posedge clk) begin
    logic [127:0] e;
    if (key_we) km[key_addr] = key_data;
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_res = '0; m_chain = '0; m_mode = 0; m_n = 1; m_left = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_left--;
        if (m_left == 0) begin
          m_busy = 0; m_done = 1; m_res = p_res; m_chain = p_chain;
        end
      end else if (start) begin
        m_mode = start_mode; m_n = int'(start_rounds_m1) + 1; m_chain = start_iv;
      end else if (blk_valid) begin
        case (m_mode)
          2'b00: begin e = ref_enc(blk_in, m_n);           p_res = e;          p_chain = m_chain; end
          2'b01: begin e = ref_enc(blk_in ^ m_chain, m_n); p_res = e;          p_chain = e;       end
          2'b10: begin e = ref_enc(m_chain, m_n);          p_res = e ^ blk_in; p_chain = p_res;   end
          default: begin e = ref_enc(m_chain, m_n);        p_res = e ^ blk_in; p_chain = e;       end
        endcase
        m_busy = 1; m_left = m_n;
      end
    end
  end

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00: return "R7";
      2'b01: return "R8";
      2'b10: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    check(busy == m_busy, "R4", "busy", 128'(busy), 128'(m_busy));
    check(done == m_done, "R4", "done", 128'(done), 128'(m_done));
    check(blk_out == m_res, {phase, "/", mode_tag(m_mode)}, "blk_out", blk_out, m_res);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL R4 watchdog: cycles %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr_key(input int a, input logic [127:0] d);
    @(negedge clk); key_we = 1; key_addr = 4'(a); key_data = d;
    @(negedge clk); key_we = 0;
  endtask

  task automatic cfg(input logic [1:0] m, input logic [3:0] rm1, input logic [127:0] iv);
    @(negedge clk); start = 1; start_mode = m; start_rounds_m1 = rm1; start_iv = iv;
    @(negedge clk); start = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic blk(input logic [127:0] d);
    @(negedge clk); blk_valid = 1; blk_in = d;
    @(negedge clk); blk_valid = 0;
    wait_idle();
  endtask

  localparam logic [127:0] STD_KEY = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] STD_PT  = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] STD_CT  = 128'h3925841d02dc09fbdc118597196a0b32;
  localparam logic [127:0] IV_A    = 128'h000102030405060708090a0b0c0d0e0f;

  initial begin
    rst_n = 0; key_we = 0; key_addr = 0; key_data = 0; start = 0; start_mode = 0;
    start_rounds_m1 = 0; start_iv = 0; blk_valid = 0; blk_in = 0;
    build_sbox();
    expand_key(STD_KEY);
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0, "R1", "flags in reset", {busy, done}, 0);
    check(blk_out == '0, "R1", "output in reset", blk_out, '0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(!busy && blk_out == '0, "R1", "after reset", blk_out, '0);

    phase = "R2";
    for (int k = 0; k < 16; k++) wr_key(k, host_keys[k]);

    phase = "R3";
    cfg(2'b00, 4'd9, '0);
    blk(STD_PT);
    check(blk_out == STD_CT, "R3", "standard vector", blk_out, STD_CT);

    phase = "R7";
    blk(128'h00112233445566778899aabbccddeeff);
    blk(STD_PT);

    phase = "R2";  // 16 rounds: entries 11..15 and wrap to entry 0
    cfg(2'b00, 4'd15, '0);
    blk(128'hdeadbeef0123456789abcdeffedcba98);
    phase = "R4";
    cfg(2'b00, 4'd0, '0);
    blk(STD_PT);
    // back-to-back single rounds with valid held high
    @(negedge clk); blk_valid = 1; blk_in = 128'h55aa55aa00ff00ff1234567890abcdef;
    repeat (6) @(negedge clk);
    blk_valid = 0;
    wait_idle();

    phase = "R8";
    cfg(2'b01, 4'd9, IV_A);
    blk(128'h6bc1bee22e409f96e93d7e117393172a);
    // R5 and R6: configuration and block pulses during a run are ignored
    @(negedge clk); blk_valid = 1; blk_in = 128'hae2d8a571e03ac9c9eb76fac45af8e51;
    @(negedge clk); blk_valid = 0;
    @(negedge clk); phase = "R5"; start = 1; start_mode = 2'b11; start_rounds_m1 = 4'd2;
    start_iv = 128'hffff; blk_valid = 1; blk_in = 128'h1;
    @(negedge clk); start = 0; blk_valid = 0;
    repeat (2) @(negedge clk); phase = "R6"; blk_valid = 1; blk_in = 128'h2;
    @(negedge clk); blk_valid = 0;
    wait_idle();
    phase = "R8";
    blk(128'h30c81c46a35ce411e5fbc1191a0a52ef);

    phase = "R9";
    cfg(2'b10, 4'd9, IV_A);
    blk(128'h6bc1bee22e409f96e93d7e117393172a);
    blk(128'hae2d8a571e03ac9c9eb76fac45af8e51);
    blk(128'h30c81c46a35ce411e5fbc1191a0a52ef);

    phase = "R10";
    cfg(2'b11, 4'd6, 128'h0f0e0d0c0b0a09080706050403020100);
    blk(128'h6bc1bee22e409f96e93d7e117393172a);
    blk(128'hae2d8a571e03ac9c9eb76fac45af8e51);
    blk(128'h0);

    phase = "R6";  // start and block in the same idle cycle: configuration wins
    @(negedge clk); start = 1; start_mode = 2'b01; start_rounds_m1 = 4'd3; start_iv = IV_A;
    blk_valid = 1; blk_in = 128'h77;
    @(negedge clk); start = 0; blk_valid = 0;
    repeat (3) @(negedge clk);
    blk(128'h77);

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule